// File: doc/BRIEF.md
# Halfword and Signed-Byte Transfer Unit

This unit carries out one already-decoded halfword or signed-byte memory transfer. A sequencer presents a 32-bit instruction word together with the current base register value, the value of the offset register, and the data to store, and pulses `start`. The unit works out the offset, adds it to or subtracts it from the base, and picks the transfer address. The address is the adjusted base for pre-indexing, or the original base for post-indexing. The unit then issues a single read or write on a request/acknowledge memory port.

When the access completes, the unit pulses `done` for one cycle. In that same cycle it presents the loaded value, widened to the full word, with a destination write strobe. It also presents the adjusted base with a base write strobe whenever the addressing mode calls for write-back. If an encoding cannot be accepted, the unit pulses `err` instead, and it makes no bus access and no register write. The output `off_idx` names the offset register, so the register file can supply `reg_off` in the same cycle as `start`.

Top module: `hxfer_unit`

## Requirements
- R1: When instruction bit 22 is 1, the offset is the 8-bit unsigned value whose upper nibble is instruction bits 11:8 and whose lower nibble is instruction bits 3:0.
- R2: When bit 22 is 0, the offset is the full `reg_off` input, and `off_idx` shows instruction bits 3:0 combinationally.
- R3: Bit 23 set adds the offset to the base; bit 23 clear subtracts it.
- R4: With bit 24 set (pre-indexing), the address is the adjusted base. The adjusted base is written back (`rn_we`=1) only when bit 21 is 1.
- R5: With bit 24 clear (post-indexing), the address is the unadjusted base, and the adjusted base is always written back.
- R6: The unit pulses `err` for one cycle and issues no request, `done` or register write in any of these cases: bits 27:25 are not 000, bit 7 or bit 4 is 0, bits 6:5 equal 00, bit 24 is 0 while bit 21 is 1, or a store (bit 20 = 0) has bits 6:5 other than 01.
- R7: Bit 20 = 1 makes a read (`mem_we`=0), and bit 20 = 0 makes a write. For halfword accesses, `mem_be` is 0011 when address bit 1 is 0 and 1100 when it is 1. A store drives `st_data[15:0]` into both halves of `mem_wdata`.
- R8: Bits 6:5 choose how loaded data is widened. Code 01 is an unsigned halfword and zero-fills bits 31:16. Code 10 is a signed byte taken from byte lane `addr[1:0]`, with `mem_be` one-hot on that lane, and bit 7 copied upward. Code 11 is a signed halfword taken from lane `addr[1]`, with bit 15 copied upward.
- R9: `mem_req` stays high, with the address and enables unchanged, until `mem_ack` is sampled high. `done` is high for exactly the one cycle after that. `rd_we` in that cycle equals the load bit.
- R10: A `start` that arrives while a transfer is outstanding is ignored.
- R11: After reset, `mem_req`, `done`, `err`, `rd_we`, `rn_we` and `busy` are all 0.
- R12: `rn_idx` shows bits 19:16 and `rd_idx` shows bits 15:12 of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the instruction on `instr` |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| reg_off | input | 32 | Offset register value |
| st_data | input | 32 | Store source register value |
| off_idx | output | 4 | Offset register index (instr bits 3:0) |
| busy | output | 1 | Transfer outstanding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Transfer address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle illegal-encoding strobe |
| rd_idx | output | 4 | Destination register index |
| rd_we | output | 1 | Destination write strobe |
| rd_val | output | 32 | Widened load result |
| rn_idx | output | 4 | Base register index |
| rn_we | output | 1 | Base write-back strobe |
| rn_val | output | 32 | Adjusted base value |

## Verification
The hardest case to reach from the ports is a second `start` that lands while a request is still waiting for its acknowledge. The stimulus makes the memory model delay its acknowledge by several cycles. During that window it pulses `start` with a different, legal instruction. It then checks that the address held on the bus does not change, that only one `done` appears, and that no second request follows. The widening rules are exercised on odd byte lanes and on the upper halfword, using read data whose sign bit is set in some cases and clear in others.

// File: rtl/hxfer_pkg.sv
package hxfer_pkg;
  typedef enum logic [1:0] {
    XT_SWAP  = 2'b00,
    XT_UHALF = 2'b01,
    XT_SBYTE = 2'b10,
    XT_SHALF = 2'b11
  } xt_e;

  typedef struct packed {
    logic       pre;
    logic       up;
    logic       wb;
    logic       load;
    xt_e        kind;
    logic [3:0] rn;
    logic [3:0] rd;
  } op_t;
endpackage

// File: rtl/hxfer_decode.sv
module hxfer_decode
  import hxfer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [31:0]   instr,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] reg_off,
  output op_t           op,
  output logic          illegal,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] new_base
);
  logic [DW-1:0] offset;

  always_comb begin
    op.pre  = instr[24];
    op.up   = instr[23];
    op.wb   = instr[21];
    op.load = instr[20];
    op.kind = xt_e'(instr[6:5]);
    op.rn   = instr[19:16];
    op.rd   = instr[15:12];
  end

  // split immediate vs register offset (R1, R2)
  assign offset   = instr[22] ? DW'({instr[11:8], instr[3:0]}) : reg_off;
  // direction (R3)
  assign new_base = op.up ? (base_val + offset) : (base_val - offset);
  // index timing (R4, R5)
  assign addr     = op.pre ? new_base : base_val;

  // encoding checks (R6)
  assign illegal = (instr[27:25] != 3'b000) || !instr[7] || !instr[4] ||
                   (op.kind == XT_SWAP) || (!op.pre && op.wb) ||
                   (!op.load && op.kind != XT_UHALF);
endmodule

// File: rtl/hxfer_extend.sv
module hxfer_extend
  import hxfer_pkg::*;
#(
  parameter int DW = 32,
  localparam int NLANE = DW / 8,
  localparam int LW = $clog2(NLANE)
) (
  input  xt_e           kind,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ext
);
  logic [DW-1:0] sh_b;
  logic [DW-1:0] sh_h;

  assign sh_b = rdata >> {lane, 3'b000};
  assign sh_h = rdata >> {lane[LW-1:1], 4'b0000};

  // widening rules (R8)
  always_comb begin
    case (kind)
      XT_UHALF: ext = {{(DW-16){1'b0}}, sh_h[15:0]};
      XT_SBYTE: ext = {{(DW-8){sh_b[7]}}, sh_b[7:0]};
      XT_SHALF: ext = {{(DW-16){sh_h[15]}}, sh_h[15:0]};
      default:  ext = '0;
    endcase
  end
endmodule

// File: rtl/hxfer_unit.sv
module hxfer_unit
  import hxfer_pkg::*;
#(
  parameter int DW = 32,
  localparam int NLANE = DW / 8,
  localparam int LW = $clog2(NLANE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      instr,
  input  logic [DW-1:0]    base_val,
  input  logic [DW-1:0]    reg_off,
  input  logic [DW-1:0]    st_data,
  output logic [3:0]       off_idx,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [NLANE-1:0] mem_be,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             done,
  output logic             err,
  output logic [3:0]       rd_idx,
  output logic             rd_we,
  output logic [DW-1:0]    rd_val,
  output logic [3:0]       rn_idx,
  output logic             rn_we,
  output logic [DW-1:0]    rn_val
);
  op_t              op_c, op_q;
  logic             ill_c;
  logic [DW-1:0]    addr_c, nb_c, nb_q, ext_c;
  logic [NLANE-1:0] be_c;

  hxfer_decode #(.DW(DW)) dec_i (
    .instr(instr), .base_val(base_val), .reg_off(reg_off),
    .op(op_c), .illegal(ill_c), .addr(addr_c), .new_base(nb_c)
  );

  hxfer_extend #(.DW(DW)) ext_i (
    .kind(op_q.kind), .lane(mem_addr[LW-1:0]), .rdata(mem_rdata), .ext(ext_c)
  );

  assign off_idx = instr[3:0];          // R2
  assign rd_idx  = op_q.rd;             // R12
  assign rn_idx  = op_q.rn;             // R12

  // lane enables (R7, R8)
  assign be_c = (op_c.kind == XT_SBYTE) ? (NLANE'(1) << addr_c[LW-1:0])
                                        : (NLANE'(3) << {addr_c[LW-1:1], 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rd_we     <= 1'b0;
      rn_we     <= 1'b0;
      rd_val    <= '0;
      rn_val    <= '0;
      nb_q      <= '0;
      op_q      <= '0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      rd_we <= 1'b0;
      rn_we <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (ill_c) begin
            err <= 1'b1;
          end else begin
            busy      <= 1'b1;
            op_q      <= op_c;
            nb_q      <= nb_c;
            mem_req   <= 1'b1;
            mem_we    <= !op_c.load;
            mem_addr  <= addr_c;
            mem_be    <= be_c;
            mem_wdata <= {(NLANE/2){st_data[15:0]}};
          end
        end
      end else if (mem_ack) begin
        busy    <= 1'b0;
        mem_req <= 1'b0;
        done    <= 1'b1;
        rd_val  <= ext_c;
        rd_we   <= op_q.load;
        rn_val  <= nb_q;
        rn_we   <= !op_q.pre || op_q.wb;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be))); // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_req && !done && !rd_we && !rn_we)); // R6
  AST_HALF_BE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && op_q.kind != XT_SBYTE) |-> ($countones(mem_be) == 2)); // R7
  AST_SBYTE_EXT: assert property (@(posedge clk) disable iff (rst)
    (done && rd_we && op_q.kind == XT_SBYTE) |-> (rd_val[DW-1:8] == {(DW-8){rd_val[7]}})); // R8
  AST_POST_WB: assert property (@(posedge clk) disable iff (rst)
    (done && !op_q.pre) |-> rn_we); // R5
endmodule

// File: tb/hxfer_unit_tb.sv
module hxfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0, base_val = '0, reg_off = '0, st_data = '0;
  logic [3:0]  off_idx;
  logic        busy, mem_req, mem_we, done, err, rd_we, rn_we;
  logic [31:0] mem_addr, mem_wdata, rd_val, rn_val;
  logic [3:0]  mem_be, rd_idx, rn_idx;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  hxfer_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .base_val(base_val),
    .reg_off(reg_off), .st_data(st_data), .off_idx(off_idx), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .err(err), .rd_idx(rd_idx), .rd_we(rd_we), .rd_val(rd_val),
    .rn_idx(rn_idx), .rn_we(rn_we), .rn_val(rn_val)
  );

  function automatic logic [31:0] mk(input logic p, u, i, w, l,
                                     input logic [3:0] rn, rd,
                                     input logic [1:0] sh, input logic [7:0] off);
    return {4'hE, 3'b000, p, u, i, w, l, rn, rd, off[7:4], 1'b1, sh, 1'b1, off[3:0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one legal transfer with acknowledge after dly cycles
  task automatic do_op(input string req, input logic [31:0] ins, base, roff, sd, rdv,
                       input int dly, input logic [31:0] e_addr, input logic [3:0] e_be,
                       input logic e_we, input logic [31:0] e_wd, input logic [31:0] e_rd,
                       input logic e_rnwe, input logic [31:0] e_rn);
    @(negedge clk);
    instr = ins; base_val = base; reg_off = roff; st_data = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, "req", {31'd0, mem_req}, 32'd1);
    chk(req, "addr", mem_addr, e_addr);
    chk(req, "be", {28'd0, mem_be}, {28'd0, e_be});
    chk("R7", "we", {31'd0, mem_we}, {31'd0, e_we});
    if (e_we) chk("R7", "wdata", mem_wdata, e_wd);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R9", "req held", {31'd0, mem_req}, 32'd1);
      chk("R9", "addr held", mem_addr, e_addr);
    end
    mem_rdata = rdv; mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R9", "done", {31'd0, done}, 32'd1);
    chk("R9", "rd_we", {31'd0, rd_we}, {31'd0, !e_we});
    if (!e_we) chk(req, "rd_val", rd_val, e_rd);
    chk(req, "rn_we", {31'd0, rn_we}, {31'd0, e_rnwe});
    if (e_rnwe) chk(req, "rn_val", rn_val, e_rn);
    chk("R12", "rd_idx", {28'd0, rd_idx}, {28'd0, ins[15:12]});
    chk("R12", "rn_idx", {28'd0, rn_idx}, {28'd0, ins[19:16]});
    @(negedge clk);
    chk("R9", "done drop", {31'd0, done}, 32'd0);
    chk("R9", "req drop", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic do_bad(input string what, input logic [31:0] ins);
    @(negedge clk);
    instr = ins; base_val = 32'h100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6", {what, " err"}, {31'd0, err}, 32'd1);
    chk("R6", {what, " req"}, {31'd0, mem_req}, 32'd0);
    chk("R6", {what, " wr"}, {30'd0, rd_we, rn_we}, 32'd0);
    @(negedge clk);
    chk("R6", {what, " err drop"}, {31'd0, err}, 32'd0);
    chk("R6", {what, " no done"}, {31'd0, done}, 32'd0);
  endtask

  task automatic test_reset;
    chk("R11", "req", {31'd0, mem_req}, 32'd0);
    chk("R11", "strobes", {27'd0, done, err, rd_we, rn_we, busy}, 32'd0);
  endtask

  task automatic test_offidx;
    @(negedge clk);
    instr = mk(1, 1, 0, 0, 1, 4'd2, 4'd3, 2'b01, 8'h0B);
    #1;
    chk("R2", "off_idx", {28'd0, off_idx}, 32'd11);
  endtask

  task automatic test_busy;
    @(negedge clk);
    instr = mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h10);
    base_val = 32'h6000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    instr = mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h40);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R10", "addr kept", mem_addr, 32'h6010);
    mem_rdata = 32'h1234; mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R10", "done", {31'd0, done}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "no 2nd req", {30'd0, mem_req, done}, 32'd0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_offidx();
    // R1 R4 pre up imm, no wb, uhalf low half zero-filled (R8)
    do_op("R1", mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h24), 32'h1000, 0, 0, 32'hABCD8765, 0,
          32'h1024, 4'b0011, 0, 0, 32'h00008765, 0, 0);
    // R3 R4 pre down wb, signed byte lane 1 negative (R8)
    do_op("R3", mk(1, 0, 1, 1, 1, 4'd4, 4'd5, 2'b10, 8'h13), 32'h2000, 0, 0, 32'h11228044, 2,
          32'h1FED, 4'b0010, 0, 0, 32'hFFFFFF80, 1, 32'h1FED);
    // R2 R5 post up reg offset, signed halfword upper negative (R8)
    do_op("R5", mk(0, 1, 0, 0, 1, 4'd6, 4'd7, 2'b11, 8'h05), 32'h3002, 32'h100, 0, 32'h9ABC0000, 1,
          32'h3002, 4'b1100, 0, 0, 32'hFFFF9ABC, 1, 32'h3102);
    // R8 signed byte lane 3 positive
    do_op("R8", mk(1, 1, 1, 0, 1, 4'd8, 4'd9, 2'b10, 8'h03), 32'h10, 0, 0, 32'h7F000000, 0,
          32'h13, 4'b1000, 0, 0, 32'h0000007F, 0, 0);
    // R8 signed halfword low lane positive
    do_op("R8", mk(1, 1, 1, 0, 1, 4'd8, 4'd9, 2'b11, 8'h00), 32'h20, 0, 0, 32'hFFFF7001, 0,
          32'h20, 4'b0011, 0, 0, 32'h00007001, 0, 0);
    // R7 store, upper half enables
    do_op("R7", mk(1, 1, 1, 0, 0, 4'd10, 4'd11, 2'b01, 8'hFE), 32'h4000, 0, 32'hDEADBEEF, 0, 1,
          32'h40FE, 4'b1100, 1, 32'hBEEFBEEF, 0, 0, 0);
    // R5 R7 store post down reg offset
    do_op("R5", mk(0, 0, 0, 0, 0, 4'd12, 4'd13, 2'b01, 8'h03), 32'h5000, 32'h10, 32'h0000CAFE, 0, 0,
          32'h5000, 4'b0011, 1, 32'hCAFECAFE, 0, 1, 32'h4FF0);
    do_bad("post wb", mk(0, 1, 1, 1, 1, 4'd1, 4'd2, 2'b01, 8'h02));
    do_bad("swap", mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b00, 8'h02));
    do_bad("hi bits", mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h02) | 32'h0200_0000);
    do_bad("bit7", mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h02) & ~32'h80);
    do_bad("bit4", mk(1, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h02) & ~32'h10);
    do_bad("sbyte store", mk(1, 1, 1, 0, 0, 4'd1, 4'd2, 2'b10, 8'h02));
    test_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule